// File: doc/BRIEF.md
# SD Host Status, Configuration and Debug Register Bank

This block holds the host-side status word, the host configuration word, a one-bit card power control and the debug-mode word of an SD host controller. It also drives the controller's single interrupt line. The command and data engines do not write these registers through the register port. They raise one-cycle set pulses on individual status bits, report the current FIFO fill level, and load a new state code into the debug word. Software reads all four registers through a simple register port. It clears status bits by writing ones to them, and it writes the configuration, power and debug words directly.

The status word is write-one-to-clear, and a hardware set pulse on a bit has priority over a software clear of that bit in the same cycle. The interrupt line is the OR of the three interrupt-class status bits (busy, block and SDIO). The other status bits never drive it. The debug word shows the live FIFO level in a 5-bit field and the state code in its low nibble. A software write that carries the power-down code 0xF in the low nibble stores 0 in that nibble instead.

Register offsets (byte addresses): status 0x20, power control 0x30, debug 0x34, configuration 0x38. Reads have no side effects and take effect combinationally. Writes take effect at the clock edge on which `reg_wr` is high. No port carries a data stream, so there is no valid/ready handshake and no back-pressure; every pin is plain control or status.

Top module: `sdh_status_regs`

## Requirements
- R1: After reset, the status, configuration and power registers read 0, the debug word reads 0x0000C60F while the FIFO level input is 0, and `irq` is low.
- R2: A pulse on `sts_set[k]` sets status bit k at the next clock edge. The implemented bits are 10 busy-irq, 9 block-irq, 8 SDIO-irq, 7 read/write timeout, 6 command timeout, 5 CRC16 error, 4 CRC7 error, 3 FIFO error and 0 data flag. Bits 2:1 and 31:11 always read 0.
- R3: A write to offset 0x20 clears every status bit that is 1 in the written data and leaves the other bits unchanged.
- R4: When a set pulse and a software clear hit the same status bit in the same cycle, the bit ends up set.
- R5: `irq` is high exactly when status bit 10, 9 or 8 is set. Other status bits have no effect on it. After a write that clears the last of these bits, `irq` is low from the next cycle.
- R6: The configuration register at 0x38 stores bits 10, 8, 5, 4, 3, 2, 1 and 0 (mask 0x53F) as written. All other bits read 0. Its value is driven on `cfg_q`.
- R7: A write to offset 0x34 stores bits 31:9 as written. It stores the low nibble as written, except that 0xF is stored as 0.
- R8: Debug bits 8:4 always show the live `fifo_level` input. Data written to those bits has no effect.
- R9: `fsm_load` loads `fsm_code` into the debug low nibble (0x1 means data mode). If it coincides with a software debug write, the loaded code wins for the nibble.
- R10: The power control register at 0x30 stores bit 0 of the written data, reads it back in bit 0, and drives it on `pwr_on`.
- R11: A read from any other offset returns 0. A write to any other offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| sts_set | input | 11 | One-cycle set pulses from the engines, one per status bit |
| fifo_level | input | 5 | Current FIFO fill level |
| fsm_load | input | 1 | Engine loads a new state code |
| fsm_code | input | 4 | State code to load |
| cfg_q | output | 11 | Current configuration bits |
| pwr_on | output | 1 | Card power control |
| irq | output | 1 | Interrupt line |

## Verification
Two pairs of functions can coincide in one cycle. The first is an engine set pulse and a software write-one-to-clear on the same status bit. The second is an engine state-code load and a software write to the debug word. The bench provokes each pair by driving the set pulse (or the load) and the register write on the same falling edge, so that a single rising edge captures both. It then reads the register back and requires the hardware side to win: the status bit stays 1 with `irq` still high, and the low nibble holds the loaded code rather than the written one. A follow-up clear with no set pulse confirms that the clear path itself still works.

// File: rtl/sdh_regs_pkg.sv
package sdh_regs_pkg;
  localparam int OFF_STATUS = 'h20;
  localparam int OFF_POWER  = 'h30;
  localparam int OFF_DEBUG  = 'h34;
  localparam int OFF_CONFIG = 'h38;

  // implemented status bits, interrupt-class status bits, implemented config bits
  localparam logic [10:0] STS_VALID    = 11'h7F9;
  localparam logic [10:0] STS_IRQ_MASK = 11'h700;
  localparam logic [10:0] CFG_VALID    = 11'h53F;

  localparam logic [31:0] DBG_RESET     = 32'h0000_C60F;
  localparam logic [3:0]  DBG_CODE_PWRDN = 4'hF;
  localparam logic [3:0]  DBG_CODE_CLEAN = 4'h0;

  typedef enum logic [1:0] {
    SEL_NONE, SEL_STATUS, SEL_DEBUG, SEL_OTHER
  } wr_kind_e;
endpackage

// File: rtl/sdh_status_bank.sv
module sdh_status_bank #(
  parameter int          W     = 11,
  parameter logic [W-1:0] VALID = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_en,
  input  logic [W-1:0] clr_mask,
  input  logic [W-1:0] set_vec,
  output logic [W-1:0] sts_q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (VALID[i]) begin : g_impl
      logic bit_q;
      always_ff @(posedge clk) begin
        if (!rst_n)
          bit_q <= 1'b0;
        else if (set_vec[i])
          bit_q <= 1'b1;            // hardware set has priority
        else if (clr_en && clr_mask[i])
          bit_q <= 1'b0;
      end
      assign sts_q[i] = bit_q;
    end else begin : g_rsvd
      logic unused_rsvd;
      assign unused_rsvd = set_vec[i] ^ clr_mask[i];
      assign sts_q[i] = 1'b0;
    end
  end
endmodule

// File: rtl/sdh_cfg_bank.sv
module sdh_cfg_bank #(
  parameter int           W     = 11,
  parameter logic [W-1:0] VALID = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cfg_q
);
  logic [W-1:0] cfg_r;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cfg_r <= '0;
    else if (wr_en)
      cfg_r <= wdata & VALID;
  end

  assign cfg_q = cfg_r;
endmodule

// File: rtl/sdh_debug_bank.sv
module sdh_debug_bank
  import sdh_regs_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CODE_W = 4,
  parameter int LVL_W  = 5,
  localparam int HI_LSB = CODE_W + LVL_W,
  localparam int HI_W   = DATA_W - HI_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              fsm_load,
  input  logic [CODE_W-1:0] fsm_code,
  input  logic [LVL_W-1:0]  fifo_level,
  output logic [DATA_W-1:0] dbg_word,
  output logic [CODE_W-1:0] code_q
);
  logic [HI_W-1:0]   hi_r;
  logic [CODE_W-1:0] code_r;
  logic [CODE_W-1:0] sw_code;
  logic              unused_lvl_bits;

  // software power-down code is stored as the clean code
  assign sw_code = (wdata[CODE_W-1:0] == CODE_W'(DBG_CODE_PWRDN))
                   ? CODE_W'(DBG_CODE_CLEAN) : wdata[CODE_W-1:0];
  assign unused_lvl_bits = ^wdata[HI_LSB-1:CODE_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_r   <= DBG_RESET[DATA_W-1:HI_LSB];
      code_r <= DBG_RESET[CODE_W-1:0];
    end else begin
      if (wr_en)
        hi_r <= wdata[DATA_W-1:HI_LSB];
      if (fsm_load)
        code_r <= fsm_code;        // engine load wins over software
      else if (wr_en)
        code_r <= sw_code;
    end
  end

  assign dbg_word = {hi_r, fifo_level, code_r};
  assign code_q   = code_r;
endmodule

// File: rtl/sdh_status_regs.sv
module sdh_status_regs
  import sdh_regs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int STS_W  = 11,
  parameter int CFG_W  = 11,
  parameter int LVL_W  = 5,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [STS_W-1:0]  sts_set,
  input  logic [LVL_W-1:0]  fifo_level,
  input  logic              fsm_load,
  input  logic [CODE_W-1:0] fsm_code,
  output logic [CFG_W-1:0]  cfg_q,
  output logic              pwr_on,
  output logic              irq
);
  logic              hit_sts, hit_pwr, hit_dbg, hit_cfg;
  logic [STS_W-1:0]  sts_q;
  logic [DATA_W-1:0] dbg_word;
  logic [CODE_W-1:0] dbg_code;
  logic              pwr_r;

  assign hit_sts = (reg_addr == ADDR_W'(OFF_STATUS));
  assign hit_pwr = (reg_addr == ADDR_W'(OFF_POWER));
  assign hit_dbg = (reg_addr == ADDR_W'(OFF_DEBUG));
  assign hit_cfg = (reg_addr == ADDR_W'(OFF_CONFIG));

  sdh_status_bank #(.W(STS_W), .VALID(STS_VALID[STS_W-1:0])) u_sts (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_en   (reg_wr && hit_sts),
    .clr_mask (reg_wdata[STS_W-1:0]),
    .set_vec  (sts_set),
    .sts_q    (sts_q)
  );

  sdh_cfg_bank #(.W(CFG_W), .VALID(CFG_VALID[CFG_W-1:0])) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (reg_wr && hit_cfg),
    .wdata (reg_wdata[CFG_W-1:0]),
    .cfg_q (cfg_q)
  );

  sdh_debug_bank #(.DATA_W(DATA_W), .CODE_W(CODE_W), .LVL_W(LVL_W)) u_dbg (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (reg_wr && hit_dbg),
    .wdata      (reg_wdata),
    .fsm_load   (fsm_load),
    .fsm_code   (fsm_code),
    .fifo_level (fifo_level),
    .dbg_word   (dbg_word),
    .code_q     (dbg_code)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)
      pwr_r <= 1'b0;
    else if (reg_wr && hit_pwr)
      pwr_r <= reg_wdata[0];
  end
  assign pwr_on = pwr_r;

  always_comb begin
    reg_rdata = '0;
    if (hit_sts)      reg_rdata = DATA_W'(sts_q);
    else if (hit_pwr) reg_rdata = DATA_W'(pwr_r);
    else if (hit_dbg) reg_rdata = dbg_word;
    else if (hit_cfg) reg_rdata = DATA_W'(cfg_q);
  end

  assign irq = |(sts_q & STS_IRQ_MASK[STS_W-1:0]);
endmodule

// File: rtl/sdh_status_regs_chk.sv
module sdh_status_regs_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int STS_W  = 11,
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [STS_W-1:0]  sts_set,
  input logic              fsm_load,
  input logic [STS_W-1:0]  sts_q,
  input logic [CODE_W-1:0] dbg_code,
  input logic              irq
);
  // R1
  reset_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (sts_q == '0 && !irq));

  // R2
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sts_q & ~$past(sts_q) & ~$past(sts_set)) == '0));

  // R3
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'('h20)) |=>
      ((sts_q & $past(reg_wdata[STS_W-1:0] & ~sts_set)) == '0));

  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_set[9] && reg_wr && reg_addr == ADDR_W'('h20) && reg_wdata[9]) |=>
      (sts_q[9] && irq));

  // R5
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(|sts_set[10:8]));

  // R7
  pwrdown_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'('h34) && reg_wdata[3:0] == 4'hF && !fsm_load)
      |=> (dbg_code == '0));
endmodule

bind sdh_status_regs sdh_status_regs_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STS_W(STS_W), .CODE_W(CODE_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_wr   (reg_wr),
  .reg_addr (reg_addr),
  .reg_wdata(reg_wdata),
  .sts_set  (sts_set),
  .fsm_load (fsm_load),
  .sts_q    (sts_q),
  .dbg_code (dbg_code),
  .irq      (irq)
);

// File: tb/tb_sdh_status_regs.sv
`timescale 1ns/1ps
module tb_sdh_status_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [10:0] sts_set = '0;
  logic [4:0]  fifo_level = '0;
  logic        fsm_load = 1'b0;
  logic [3:0]  fsm_code = '0;
  logic [10:0] cfg_q;
  logic        pwr_on;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  sdh_status_regs dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sts_set(sts_set),
    .fifo_level(fifo_level), .fsm_load(fsm_load), .fsm_code(fsm_code),
    .cfg_q(cfg_q), .pwr_on(pwr_on), .irq(irq)
  );

  // vector: op(2) addr(8) data(32) expect(32); op 0 read, 1 write, 2 set pulse
  localparam int NV = 22;
  localparam logic [73:0] VEC [NV] = '{
    {2'd0, 8'h20, 32'h0,          32'h0},          // R1 status
    {2'd0, 8'h38, 32'h0,          32'h0},          // R1 config
    {2'd0, 8'h34, 32'h0,          32'h0000C60F},   // R1 debug
    {2'd0, 8'h30, 32'h0,          32'h0},          // R1 power
    {2'd2, 8'h00, 32'h7FF,        32'h0},          // R2 set all
    {2'd0, 8'h20, 32'h0,          32'h7F9},        // R2
    {2'd1, 8'h20, 32'h0F0,        32'h0},          // R3 partial clear
    {2'd0, 8'h20, 32'h0,          32'h709},        // R3
    {2'd1, 8'h20, 32'hFFFFFFFF,   32'h0},          // R3 full clear
    {2'd0, 8'h20, 32'h0,          32'h0},          // R3
    {2'd1, 8'h38, 32'hFFFFFFFF,   32'h0},          // R6
    {2'd0, 8'h38, 32'h0,          32'h53F},        // R6
    {2'd1, 8'h38, 32'h00000412,   32'h0},          // R6
    {2'd0, 8'h38, 32'h0,          32'h412},        // R6
    {2'd1, 8'h34, 32'h1234567F,   32'h0},          // R7 power-down code
    {2'd0, 8'h34, 32'h0,          32'h12345600},   // R7 R8
    {2'd1, 8'h34, 32'hABCD0003,   32'h0},          // R7
    {2'd0, 8'h34, 32'h0,          32'hABCD0003},   // R7
    {2'd1, 8'h30, 32'hFFFFFFFF,   32'h0},          // R10
    {2'd0, 8'h30, 32'h0,          32'h1},          // R10
    {2'd1, 8'h24, 32'hFFFFFFFF,   32'h0},          // R11 unmapped write
    {2'd0, 8'h24, 32'h0,          32'h0}           // R11 unmapped read
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic pulse(input logic [10:0] v);
    @(negedge clk);
    sts_set = v;
    @(negedge clk);
    sts_set = '0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
    reg_addr = a;
    #0.5;
    check(req, reg_rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 pwr_on", {31'd0, pwr_on}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][73:72])
        2'd0: rd("table", VEC[i][71:64], VEC[i][31:0]);
        2'd1: wr(VEC[i][71:64], VEC[i][63:32]);
        default: pulse(VEC[i][42:32]);
      endcase
    end
    check("R6 cfg_q", {21'd0, cfg_q}, 32'h412);
    check("R10 pwr_on", {31'd0, pwr_on}, 32'd1);
    // R11: unmapped write left every register as it was
    rd("R11 status", 8'h20, 32'h0);
    rd("R11 config", 8'h38, 32'h412);
    rd("R11 debug", 8'h34, 32'hABCD0003);

    // R5: non-interrupt bits leave irq low
    pulse(11'h0F9);
    check("R5 no irq", {31'd0, irq}, 32'd0);
    pulse(11'h100);
    check("R5 irq", {31'd0, irq}, 32'd1);
    wr(8'h20, 32'h100);
    check("R5 irq cleared", {31'd0, irq}, 32'd0);
    rd("R5 others kept", 8'h20, 32'h0F9);
    wr(8'h20, 32'h7FF);

    // R4: set and clear on bit 9 in the same cycle
    pulse(11'h200);
    @(negedge clk);
    sts_set = 11'h200; reg_wr = 1'b1; reg_addr = 8'h20; reg_wdata = 32'h200;
    @(negedge clk);
    sts_set = '0; reg_wr = 1'b0; reg_wdata = '0;
    rd("R4 set wins", 8'h20, 32'h200);
    check("R4 irq held", {31'd0, irq}, 32'd1);
    wr(8'h20, 32'h200);
    rd("R4 later clear", 8'h20, 32'h0);

    // R8: live FIFO level, written level bits ignored
    fifo_level = 5'd17;
    rd("R8 level", 8'h34, 32'hABCD0113);
    wr(8'h34, 32'h000001F2);
    fifo_level = 5'd3;
    rd("R8 write ignored", 8'h34, 32'h00000032);

    // R9: engine load alone, then against a software write
    @(negedge clk);
    fsm_load = 1'b1; fsm_code = 4'h1;
    @(negedge clk);
    fsm_load = 1'b0;
    rd("R9 load", 8'h34, 32'h00000031);
    @(negedge clk);
    fsm_load = 1'b1; fsm_code = 4'h1;
    reg_wr = 1'b1; reg_addr = 8'h34; reg_wdata = 32'h00000205;
    @(negedge clk);
    fsm_load = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    rd("R9 load wins", 8'h34, 32'h00000231);

    // R7: power-down code against a nonzero nibble
    wr(8'h34, 32'h0000000F);
    rd("R7 F stored as 0", 8'h34, 32'h00000030);

    // R1: reset restores defaults
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    fifo_level = '0;
    rd("R1 debug again", 8'h34, 32'h0000C60F);
    rd("R1 config again", 8'h38, 32'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule